// File: doc/BRIEF.md
# Two-channel compare-match timer

This block holds two independent up-counters. Each counter advances once every N clock cycles, where N is a power-of-two divide chosen per channel. When a counter advances while it already holds its channel's compare value, it returns to zero and keeps counting. The channel raises a one-cycle interrupt pulse at that moment if its interrupt enable is set. Software uses the block as a periodic tick source. The tick period is (compare + 1) × N clock cycles.

A single start register turns each channel's counting on and off. The counter and compare registers can be written at any time. All registers are reached over a simple 16-bit register bus that accepts only aligned halfword accesses. A read returns data in the same cycle. A write takes effect at the next clock edge.

Top module: `cmtimer_pair`

## Requirements
- R1: After reset the start register, both control registers and both counters read 0, and both compare registers read 0xFFFF.
- R2: Control bits [1:0] hold a divide code k. A running channel's counter advances by one every 2^(3+2k) clock cycles, which gives 8, 32, 128 or 512.
- R3: Start bit c (bit 0 for channel 0, bit 1 for channel 1) enables channel c. While the bit is clear, the channel's count holds its value. After the bit is set again, the first advance comes a full divide period later, because the divide phase restarts.
- R4: When a channel advances while its count equals its compare value, the count becomes 0 and counting continues. The repeat period is therefore (compare + 1) × divide cycles.
- R5: Each clear-on-match raises that channel's interrupt output for exactly one cycle, in the cycle where the count first reads 0, provided control bit 6 is set. With bit 6 clear, no pulse appears.
- R6: A counter write takes effect at the next clock edge, even while the channel runs. A count above the compare value keeps counting up through 0xFFFF to 0 with no pulse, and then matches normally.
- R7: The byte offsets are: 0 for start; 2, 4 and 6 for channel 0's control, counter and compare; 8, 10 and 12 for channel 1's control, counter and compare.
- R8: Control reads return only bits 6 and 1:0, with all other bits 0. Start reads return only bits 1:0. Reads of odd or unmapped offsets return 0xFFFF, and writes to them change nothing.
- R9: Activity on one channel never changes the other channel's count or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the halfword register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| cm_irq | output | 2 | Per-channel compare-match interrupt pulse |

## Verification
The bench builds the block with its default parameters: two channels, 16-bit counters, and a divide base of 3 with a step of 2. With these values, all four divides from 8 to 512 can be exercised within a short run. Preloading the counter near 0xFFFF brings the full 16-bit rollover within reach of a few hundred cycles. Random compare values from 1 to 12, random divide codes and random phase offsets check the count and the pulse totals against a closed-form period model. Directed cases cover the stop/restart phase, the over-compare wrap and the read-back masks.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
   // control register field layout
   localparam int CKS_W       = 2;
   localparam int IE_BIT      = 6;
   localparam int REGS_PER_CH = 3;

   typedef struct packed {
      logic ctrl;
      logic cnt;
      logic cmp;
   } chan_we_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
   parameter int PSC_BASE = 3,
   parameter int PSC_STEP = 2,
   parameter int CKS_W    = 2,
   localparam int PSC_W   = PSC_BASE + PSC_STEP * ((1 << CKS_W) - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CKS_W-1:0] cks_i,
   output logic             tick_o
);
   generate
      if (PSC_BASE < 1) begin : g_bad_base
         $error("cmt_prescaler: PSC_BASE must be at least 1");
      end
      if (PSC_STEP < 1) begin : g_bad_step
         $error("cmt_prescaler: PSC_STEP must be at least 1");
      end
   endgenerate

   logic [PSC_W-1:0] psc_q;
   logic [PSC_W-1:0] mask;
   int               shamt;

   always_comb begin
      shamt = PSC_W - (PSC_BASE + PSC_STEP * int'(cks_i));
      mask  = {PSC_W{1'b1}} >> shamt;
   end

   assign tick_o = run_i && ((psc_q & mask) == mask);

   // phase restarts whenever the channel is stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      psc_q <= '0;
      else if (!run_i) psc_q <= '0;
      else             psc_q <= psc_q + 1'b1;
   end

   assert_idle_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_i) |-> (psc_q == '0));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
   parameter int CNT_W    = 16,
   parameter int PSC_BASE = 3,
   parameter int PSC_STEP = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run_i,
   input  cmt_pkg::chan_we_t        we_i,
   input  logic [CNT_W-1:0]         wdata_i,
   output logic [cmt_pkg::CKS_W-1:0] cks_o,
   output logic                     ie_o,
   output logic [CNT_W-1:0]         cnt_o,
   output logic [CNT_W-1:0]         cmp_o,
   output logic                     irq_o
);
   import cmt_pkg::*;

   generate
      if (CNT_W <= IE_BIT) begin : g_bad_width
         $error("cmt_channel: CNT_W too narrow for the control fields");
      end
   endgenerate

   logic [CKS_W-1:0] cks_q;
   logic             ie_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cmp_q;
   logic             irq_q;
   logic             tick;
   logic             hit;

   cmt_prescaler #(
      .PSC_BASE (PSC_BASE),
      .PSC_STEP (PSC_STEP),
      .CKS_W    (CKS_W)
   ) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_i),
      .cks_i  (cks_q),
      .tick_o (tick)
   );

   assign hit = (cnt_q == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cks_q <= '0;
         ie_q  <= 1'b0;
         cmp_q <= '1;
      end else begin
         if (we_i.ctrl) begin
            cks_q <= wdata_i[CKS_W-1:0];
            ie_q  <= wdata_i[IE_BIT];
         end
         if (we_i.cmp) cmp_q <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= tick && hit && ie_q;
         if (we_i.cnt)  cnt_q <= wdata_i;
         else if (tick) cnt_q <= hit ? '0 : cnt_q + 1'b1;
      end
   end

   assign cks_o = cks_q;
   assign ie_o  = ie_q;
   assign cnt_o = cnt_q;
   assign cmp_o = cmp_q;
   assign irq_o = irq_q;

   assert_clear_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (cnt_q == '0 || $past(we_i.cnt)));
   assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);
   assert_pulse_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(ie_q));
   assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run_i) && !$past(we_i.cnt)) |-> $stable(cnt_q));
   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(we_i.cnt) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1
                            || cnt_q == '0));
endmodule

// File: rtl/cmt_bus_decode.sv
module cmt_bus_decode #(
   parameter int NCH = 2,
   parameter int DW  = 16,
   parameter int AW  = 4
) (
   input  logic                         sel_i,
   input  logic                         wr_i,
   input  logic [AW-1:0]                addr_i,
   input  logic [NCH-1:0]               start_rb_i,
   input  logic [NCH-1:0][DW-1:0]       ctrl_rb_i,
   input  logic [NCH-1:0][DW-1:0]       cnt_rb_i,
   input  logic [NCH-1:0][DW-1:0]       cmp_rb_i,
   output logic                         start_we_o,
   output cmt_pkg::chan_we_t [NCH-1:0]  ch_we_o,
   output logic [DW-1:0]                rdata_o
);
   import cmt_pkg::*;

   int   idx;
   logic aligned;
   logic wr_en;

   always_comb begin
      idx        = int'(addr_i[AW-1:1]);
      aligned    = !addr_i[0];
      wr_en      = sel_i && wr_i && aligned;
      start_we_o = wr_en && (idx == 0);
      ch_we_o    = '0;
      rdata_o    = '1;
      if (aligned && idx == 0) rdata_o = DW'(start_rb_i);
      for (int c = 0; c < NCH; c++) begin
         if (aligned && idx == 1 + REGS_PER_CH * c) begin
            rdata_o          = ctrl_rb_i[c];
            ch_we_o[c].ctrl  = wr_en;
         end
         if (aligned && idx == 2 + REGS_PER_CH * c) begin
            rdata_o          = cnt_rb_i[c];
            ch_we_o[c].cnt   = wr_en;
         end
         if (aligned && idx == 3 + REGS_PER_CH * c) begin
            rdata_o          = cmp_rb_i[c];
            ch_we_o[c].cmp   = wr_en;
         end
      end
   end
endmodule

// File: rtl/cmtimer_pair.sv
module cmtimer_pair #(
   parameter int NCH      = 2,
   parameter int CNT_W    = 16,
   parameter int PSC_BASE = 3,
   parameter int PSC_STEP = 2,
   localparam int ADDR_W  = $clog2(2 * (1 + cmt_pkg::REGS_PER_CH * NCH))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic [NCH-1:0]    cm_irq
);
   import cmt_pkg::*;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("cmtimer_pair: NCH must be at least 1");
      end
      if (NCH > CNT_W) begin : g_bad_start
         $error("cmtimer_pair: start register cannot hold NCH bits");
      end
   endgenerate

   logic [NCH-1:0]            start_q;
   logic                      start_we;
   chan_we_t [NCH-1:0]        ch_we;
   logic [NCH-1:0][CNT_W-1:0] ctrl_rb;
   logic [NCH-1:0][CNT_W-1:0] cnt_rb;
   logic [NCH-1:0][CNT_W-1:0] cmp_rb;

   cmt_bus_decode #(
      .NCH (NCH),
      .DW  (CNT_W),
      .AW  (ADDR_W)
   ) u_dec (
      .sel_i      (bus_sel),
      .wr_i       (bus_wr),
      .addr_i     (bus_addr),
      .start_rb_i (start_q),
      .ctrl_rb_i  (ctrl_rb),
      .cnt_rb_i   (cnt_rb),
      .cmp_rb_i   (cmp_rb),
      .start_we_o (start_we),
      .ch_we_o    (ch_we),
      .rdata_o    (bus_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        start_q <= '0;
      else if (start_we) start_q <= bus_wdata[NCH-1:0];
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic [CKS_W-1:0] cks;
         logic             ie;

         cmt_channel #(
            .CNT_W    (CNT_W),
            .PSC_BASE (PSC_BASE),
            .PSC_STEP (PSC_STEP)
         ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_i   (start_q[c]),
            .we_i    (ch_we[c]),
            .wdata_i (bus_wdata),
            .cks_o   (cks),
            .ie_o    (ie),
            .cnt_o   (cnt_rb[c]),
            .cmp_o   (cmp_rb[c]),
            .irq_o   (cm_irq[c])
         );

         always_comb begin
            ctrl_rb[c]               = '0;
            ctrl_rb[c][CKS_W-1:0]    = cks;
            ctrl_rb[c][IE_BIT]       = ie;
         end
      end
   endgenerate

   assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_we, ch_we}));
endmodule

// File: tb/cmtimer_pair_tb.sv
`timescale 1ns/1ps
module cmtimer_pair_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  cm_irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int pulses [2] = '{0, 0};
   int wide_err = 0;
   logic [1:0] irq_prev = '0;

   always #5 clk = ~clk;

   cmtimer_pair u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cm_irq    (cm_irq)
   );

   always @(negedge clk) begin
      for (int c = 0; c < 2; c++) begin
         if (cm_irq[c]) pulses[c]++;
         if (cm_irq[c] && irq_prev[c]) wide_err++;
      end
      irq_prev = cm_irq;
   end

   function automatic int div_of(int k);
      return 1 << (3 + 2 * k);
   endfunction

   function automatic int exp_cnt(int ticks, int cmp);
      return ticks % (cmp + 1);
   endfunction

   function automatic int exp_pulses(int ticks, int cmp, int ie);
      return ie ? ticks / (cmp + 1) : 0;
   endfunction

   task automatic chk(string tag, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
      end
   endtask

   // called in the low phase; one edge passes
   task automatic wr(logic [3:0] a, logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output int d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = int'(bus_rdata);
      bus_sel = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int v;
      int p0;
      int p1;
      void'($urandom(5150));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R7 map
      rd(4'd0, v);  chk("R1 start", v, 0);
      rd(4'd2, v);  chk("R1 ctrl0", v, 0);
      rd(4'd4, v);  chk("R1 cnt0", v, 0);
      rd(4'd6, v);  chk("R1 cmp0", v, 16'hFFFF);
      idle(1);
      rd(4'd8, v);  chk("R1 ctrl1", v, 0);
      rd(4'd10, v); chk("R1 cnt1", v, 0);
      rd(4'd12, v); chk("R1 cmp1", v, 16'hFFFF);
      idle(1);

      // R8 read-back masks and unmapped space
      rd(4'd14, v); chk("R8 unmapped read", v, 16'hFFFF);
      rd(4'd5, v);  chk("R8 odd read", v, 16'hFFFF);
      wr(4'd2, 16'hFFFF);
      rd(4'd2, v);  chk("R8 ctrl mask", v, 16'h0043);
      wr(4'd2, 16'h0000);
      wr(4'd14, 16'h1234);
      wr(4'd7, 16'h0000);
      rd(4'd6, v);  chk("R8 unmapped write cmp0", v, 16'hFFFF);
      rd(4'd12, v); chk("R8 unmapped write cmp1", v, 16'hFFFF);
      rd(4'd4, v);  chk("R8 unmapped write cnt0", v, 0);
      idle(1);
      wr(4'd0, 16'hFFFC);
      rd(4'd0, v);  chk("R8 start mask", v, 0);

      // R7 map: channel 1 compare lands at offset 12 only
      wr(4'd12, 16'h00AA);
      rd(4'd12, v); chk("R7 cmp1", v, 16'h00AA);
      rd(4'd6, v);  chk("R7 cmp0 untouched", v, 16'hFFFF);
      idle(1);

      // R3 stop holds, restart resets phase (divide 8)
      wr(4'd4, 16'h0000);
      wr(4'd0, 16'h0001);
      idle(12);
      rd(4'd4, v);  chk("R2 div8 count", v, 1);
      wr(4'd0, 16'h0000);
      idle(20);
      rd(4'd4, v);  chk("R3 stopped hold", v, 1);
      wr(4'd0, 16'h0001);
      idle(7);
      rd(4'd4, v);  chk("R3 phase restart early", v, 1);
      idle(1);
      rd(4'd4, v);  chk("R3 phase restart on time", v, 2);
      rd(4'd10, v); chk("R9 cnt1 idle", v, 0);

      // R6 counter write while running
      wr(4'd4, 16'h0123);
      rd(4'd4, v);  chk("R6 running write", v, 16'h0123);
      wr(4'd0, 16'h0000);

      // R6 wrap above compare, then R4/R5 match
      wr(4'd2, 16'h0040);
      wr(4'd6, 16'h0002);
      wr(4'd4, 16'hFFFE);
      p0 = pulses[0];
      wr(4'd0, 16'h0001);
      idle(8);
      rd(4'd4, v);  chk("R6 reach 0xFFFF", v, 16'hFFFF);
      idle(8);
      rd(4'd4, v);  chk("R6 roll to 0", v, 0);
      chk("R6 no pulse on roll", pulses[0] - p0, 0);
      idle(24);
      rd(4'd4, v);  chk("R4 clear on match", v, 0);
      chk("R5 pulse on match", pulses[0] - p0, 1);
      wr(4'd0, 16'h0000);

      // R5 disabled pulse
      wr(4'd2, 16'h0000);
      wr(4'd4, 16'h0000);
      p0 = pulses[0];
      wr(4'd0, 16'h0001);
      idle(8 * 3 * 2);
      chk("R5 disabled no pulse", pulses[0] - p0, 0);
      wr(4'd0, 16'h0000);

      // random: R2 divide, R4 period, R5 pulses, R9 independence
      for (int it = 0; it < 10; it++) begin
         int ch, k, cmp, ie, ticks, m, base, other, o_cnt;
         ch    = int'($urandom % 2);
         k     = int'($urandom % 4);
         cmp   = 1 + int'($urandom % 12);
         ie    = int'($urandom % 2);
         ticks = int'($urandom % 16);
         m     = ticks * div_of(k) + int'($urandom % div_of(k));
         base  = 2 + 6 * ch;
         other = 2 + 6 * (1 - ch);
         wr(4'(base), 16'((ie << 6) | k));
         wr(4'(base + 4), 16'(cmp));
         wr(4'(base + 2), 16'h0000);
         rd(4'(other + 2), o_cnt);
         p0 = pulses[ch];
         p1 = pulses[1 - ch];
         wr(4'd0, 16'(1 << ch));
         idle(m);
         rd(4'(base + 2), v);
         chk($sformatf("R2 R4 rand cnt it%0d", it), v, exp_cnt(ticks, cmp));
         chk($sformatf("R5 rand pulses it%0d", it), pulses[ch] - p0,
             exp_pulses(ticks, cmp, ie));
         rd(4'(other + 2), v);
         chk($sformatf("R9 other cnt it%0d", it), v, o_cnt);
         chk($sformatf("R9 other irq it%0d", it), pulses[1 - ch] - p1, 0);
         wr(4'd0, 16'h0000);
      end

      chk("R5 pulse one cycle wide", wide_err, 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule